// File: doc/BRIEF.md
# Non-volatile ROM Readback Checker

This block sweeps a small non-volatile ROM without pause and checks every byte it reads. The ROM holds 1 kbit, in 8 banks of 128 bits. Each bank reads back as 16 bytes, so there are 128 byte locations on a 7-bit address. Every location must hold its own address, zero-extended to 8 bits. The checker presents one address, reads it three times in a row, and then classifies the visit. If all three reads disagree with the expected byte, the stored data is wrong, and the visit counts as a persistent error. If only one or two reads disagree, a glitch hit the address or data path, and the visit counts as a transient. A third counter records completed sweeps of the whole ROM.

The read rate comes from a free-running clock-enable divider, so one design can run at slow and fast check rates, for example 2 MHz or 16 MHz equivalents, from one system clock. The ROM is external. It has a read strobe, a registered address, and one cycle of read latency.

A single state machine sequences each read through four named states:
- `ST_IDLE` waits for a divider tick and moves to `ST_FETCH` when the tick arrives.
- `ST_FETCH` raises the read strobe for one cycle and always moves to `ST_SAMPLE`.
- `ST_SAMPLE` registers the returned byte and always moves to `ST_CHECK`.
- `ST_CHECK` compares the byte, updates the visit state, and always returns to `ST_IDLE`.

Top module: `rom_readback_checker`

## Requirements
- R1: While reset is held and on the first cycle after it, `rom_addr` is 0, `rom_rd` is 0, and all three counters are 0.
- R2: Each accepted tick gives one `rom_rd` pulse of exactly one cycle. A tick that arrives while a read is in progress is dropped. With `rate_div` >= 3, reads are exactly `rate_div`+1 cycles apart. With `rate_div` = 0, they are 4 cycles apart.
- R3: Each address is read three times in succession. The address then steps by one, and 127 wraps to 0. The address is stable whenever `rom_rd` is high.
- R4: The byte is sampled on the cycle after the `rom_rd` pulse. The expected value for address A is {1'b0, A}.
- R5: A visit in which all three reads mismatch increments `persistent_cnt` by one.
- R6: A visit in which exactly one or two reads mismatch increments `transient_cnt` by one.
- R7: A visit in which all three reads match changes no counter.
- R8: `sweep_cnt` increments by one when the visit to address 127 completes, on the same edge that the address wraps to 0.
- R9: A single visit never increments both `persistent_cnt` and `transient_cnt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_div | input | 16 | Divider setting; a tick occurs every `rate_div`+1 cycles |
| rom_rd | output | 1 | One-cycle read strobe to the ROM |
| rom_addr | output | 7 | Byte address presented to the ROM |
| rom_data | input | 8 | ROM read data, valid one cycle after `rom_rd` |
| transient_cnt | output | 16 | Visits with one or two mismatching reads |
| persistent_cnt | output | 16 | Visits with three mismatching reads |
| sweep_cnt | output | 16 | Completed full sweeps of the ROM |

## Verification
The assertions check the following on every cycle:
- The strobe is always a single-cycle pulse, and the divider ticks are spaced correctly.
- The address only ever steps by one, holds during reads, and lands on 0 after a sweep completes.
- A visit never raises both error classes.

Only the bench's scenarios can show the rest, using a ROM model that injects faults on chosen reads:
- A visit is classified as clean, transient or persistent according to how many of its three reads were corrupted.
- The sample timing is right; the model drives a garbage value outside its latency slot.
- The exact read spacing at several divider settings, including a setting where ticks are dropped.

// File: rtl/rcb_pkg.sv
package rcb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FETCH  = 2'd1,
        ST_SAMPLE = 2'd2,
        ST_CHECK  = 2'd3
    } rd_state_t;
endpackage

// File: rtl/rcb_tick_div.sv
module rcb_tick_div #(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_q;

    // >= keeps the divider safe when the setting shrinks mid-count
    assign tick_o = (cnt_q >= div_i);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R2: after a tick the next one needs a zero setting
    assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (!tick_o || div_i == '0));
endmodule

// File: rtl/rcb_event_ctr.sv
module rcb_event_ctr #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    output logic [CNT_W-1:0] count_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_o <= '0;
        end else if (inc_i) begin
            count_o <= count_o + 1'b1;
        end
    end

    // R5: a count only moves when an increment was requested
    assert_ctr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(inc_i) |-> $stable(count_o));
endmodule

// File: rtl/rom_readback_checker.sv
module rom_readback_checker
    import rcb_pkg::*;
#(
    parameter int unsigned ADDR_W = 7,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DIV_W  = 16,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned READS  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  rate_div,
    output logic              rom_rd,
    output logic [ADDR_W-1:0] rom_addr,
    input  logic [DATA_W-1:0] rom_data,
    output logic [CNT_W-1:0]  transient_cnt,
    output logic [CNT_W-1:0]  persistent_cnt,
    output logic [CNT_W-1:0]  sweep_cnt
);
    localparam int unsigned IDX_W  = $clog2(READS);
    localparam int unsigned MISS_W = $clog2(READS + 1);
    localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(READS - 1);
    localparam logic [MISS_W-1:0] ALL_MISS  = MISS_W'(READS);
    localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

    rd_state_t         state_q, state_d;
    logic [DATA_W-1:0] data_q;
    logic [IDX_W-1:0]  idx_q;
    logic [MISS_W-1:0] miss_q;
    logic              tick;

    logic              in_check;
    logic              last_read;
    logic              miss_now;
    logic [MISS_W-1:0] miss_total;
    logic              inc_pers, inc_tran, inc_sweep;

    rcb_tick_div #(.DIV_W(DIV_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .div_i  (rate_div),
        .tick_o (tick)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (tick) state_d = ST_FETCH;
            ST_FETCH:  state_d = ST_SAMPLE;
            ST_SAMPLE: state_d = ST_CHECK;
            ST_CHECK:  state_d = ST_IDLE;
        endcase
    end

    // outputs and classification
    always_comb begin
        rom_rd     = (state_q == ST_FETCH);
        in_check   = (state_q == ST_CHECK);
        last_read  = (idx_q == LAST_IDX);
        miss_now   = (data_q != DATA_W'(rom_addr));
        miss_total = miss_q + MISS_W'(miss_now);
        inc_pers   = in_check && last_read && (miss_total == ALL_MISS);
        inc_tran   = in_check && last_read && (miss_total != '0) && (miss_total != ALL_MISS);
        inc_sweep  = in_check && last_read && (rom_addr == LAST_ADDR);
    end

    // datapath: address, captured byte, read index, miss tally
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rom_addr <= '0;
            data_q   <= '0;
            idx_q    <= '0;
            miss_q   <= '0;
        end else begin
            if (state_q == ST_SAMPLE) begin
                data_q <= rom_data;
            end
            if (in_check) begin
                if (last_read) begin
                    idx_q    <= '0;
                    miss_q   <= '0;
                    rom_addr <= rom_addr + 1'b1;
                end else begin
                    idx_q  <= idx_q + 1'b1;
                    miss_q <= miss_total;
                end
            end
        end
    end

    rcb_event_ctr #(.CNT_W(CNT_W)) u_tran_ctr (
        .clk(clk), .rst_n(rst_n), .inc_i(inc_tran), .count_o(transient_cnt)
    );
    rcb_event_ctr #(.CNT_W(CNT_W)) u_pers_ctr (
        .clk(clk), .rst_n(rst_n), .inc_i(inc_pers), .count_o(persistent_cnt)
    );
    rcb_event_ctr #(.CNT_W(CNT_W)) u_sweep_ctr (
        .clk(clk), .rst_n(rst_n), .inc_i(inc_sweep), .count_o(sweep_cnt)
    );

    // R2: strobe is a single-cycle pulse
    assert_rd_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rom_rd |=> !rom_rd);

    // R3: address only steps by one
    assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_addr != $past(rom_addr)) |-> (rom_addr == ADDR_W'($past(rom_addr) + 1'b1)));

    // R3: address held across a read
    assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rom_rd |-> $stable(rom_addr));

    // R9: one class per visit
    assert_one_class_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(inc_pers && inc_tran));

    // R8: sweep completion coincides with the wrap to zero
    assert_sweep_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        inc_sweep |=> (rom_addr == '0));
endmodule

// File: tb/rom_readback_checker_bench.sv
module rom_readback_checker_bench;
    localparam int NADDR = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] rate_div = 16'd3;
    logic        rom_rd;
    logic [6:0]  rom_addr;
    logic [7:0]  rom_data = 8'hFF;
    logic [15:0] transient_cnt, persistent_cnt, sweep_cnt;

    int errors = 0;
    int checks = 0;

    logic [7:0] pmask [NADDR];
    logic [2:0] tmask [NADDR];
    int         rd_k = 0;

    int         cyc = 0;
    int         last_rd = 0;
    int         last_gap = 0;
    int         seq_err = 0;
    logic [6:0] exp_addr = '0;
    int         exp_k = 0;

    int exp_t = 0, exp_p = 0, exp_s = 0;

    always #5 clk = ~clk;

    rom_readback_checker u_rom_readback_checker (
        .clk(clk), .rst_n(rst_n), .rate_div(rate_div),
        .rom_rd(rom_rd), .rom_addr(rom_addr), .rom_data(rom_data),
        .transient_cnt(transient_cnt), .persistent_cnt(persistent_cnt),
        .sweep_cnt(sweep_cnt)
    );

    // ROM model: one-cycle latency, garbage outside the latency slot (R4)
    always @(posedge clk) begin
        if (!rst_n) begin
            rd_k     <= 0;
            rom_data <= 8'hFF;
        end else if (rom_rd) begin
            rom_data <= {1'b0, rom_addr} ^ pmask[rom_addr]
                        ^ (tmask[rom_addr][rd_k] ? 8'h80 : 8'h00);
            rd_k     <= (rd_k == 2) ? 0 : rd_k + 1;
        end else begin
            rom_data <= 8'hFF;
        end
    end

    // monitor: read spacing (R2) and address order (R3)
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rst_n && rom_rd) begin
            last_gap = cyc - last_rd;
            last_rd  = cyc;
            if (rom_addr != exp_addr) seq_err = seq_err + 1;
            exp_k = exp_k + 1;
            if (exp_k == 3) begin
                exp_k    = 0;
                exp_addr = exp_addr + 7'd1;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int mism(input int a);
        if (pmask[a] != 8'h00) return 3;
        return int'(tmask[a][0]) + int'(tmask[a][1]) + int'(tmask[a][2]);
    endfunction

    task automatic gen_faults(input bit directed);
        for (int a = 0; a < NADDR; a++) begin
            int r;
            r = $urandom % 6;
            pmask[a] = 8'h00;
            tmask[a] = 3'b000;
            if (r == 0) pmask[a] = 8'h01 << ($urandom % 7);
            else if (r <= 3) tmask[a] = 3'($urandom % 8);
        end
        if (directed) begin
            pmask[0] = 8'h00; tmask[0] = 3'b000;
            pmask[127] = 8'h40; tmask[127] = 3'b000;
            pmask[64] = 8'h00; tmask[64] = 3'b001;
            pmask[65] = 8'h00; tmask[65] = 3'b110;
            pmask[66] = 8'h00; tmask[66] = 3'b111;
            pmask[67] = 8'h00; tmask[67] = 3'b100;
        end
    endtask

    task automatic run_sweep(input string tag, input int gap_exp);
        int dt, dp, clean, n;
        dt = 0; dp = 0; clean = 0;
        for (int a = 0; a < NADDR; a++) begin
            n = mism(a);
            if (n == 3) dp++;
            else if (n > 0) dt++;
            else clean++;
        end
        exp_t += dt;
        exp_p += dp;
        exp_s += 1;
        n = 0;
        while (int'(sweep_cnt) != exp_s && n < 20000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 20000) begin
            errors++;
            checks++;
            $display("FAIL R8 watchdog %s actual=%0d expected=%0d", tag, sweep_cnt, exp_s);
        end
        check({"R6 transient ", tag}, int'(transient_cnt), exp_t);
        check({"R5 R4 persistent ", tag}, int'(persistent_cnt), exp_p);
        check({"R8 sweeps ", tag}, int'(sweep_cnt), exp_s);
        check({"R7 R9 events vs clean ", tag},
              int'(transient_cnt) + int'(persistent_cnt), exp_t + exp_p + 0 * clean);
        check({"R7 clean visits ", tag}, NADDR - dt - dp, clean);
        check({"R2 read gap ", tag}, last_gap, gap_exp);
    endtask

    initial begin
        void'($urandom(32'd2718));
        gen_faults(1'b1);
        repeat (3) @(negedge clk);
        check("R1 reset addr", int'(rom_addr), 0);
        check("R1 reset rd", int'(rom_rd), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 counters", int'(transient_cnt) + int'(persistent_cnt) + int'(sweep_cnt), 0);
        check("R1 addr after reset", int'(rom_addr), 0);

        run_sweep("rate3", 4);
        gen_faults(1'b0);
        rate_div = 16'd15;
        run_sweep("rate15", 16);
        gen_faults(1'b0);
        rate_div = 16'd0;
        run_sweep("rate0", 4);

        check("R3 address order", seq_err, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule